// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block decides, while an instruction sits in the IF/ID register, whether control flow leaves the sequential path and where it goes. It decodes the opcode, runs a zero test on a forwarded register operand, sign-extends and scales the branch offset, and adds it to the instruction's PC+4. It also forms jump targets, either from the instruction's target field or from the operand register. Because all of this happens in decode, a redirect costs one fetch slot, not three.

A single mode pin selects how that one fetch slot is treated. With speculation on the sequential path (mode 0), fetch continues at PC+4 and the already fetched successor is flushed out of IF/ID only when the redirect happens. With a single architectural delay slot (mode 1), the successor always runs and is never flushed. The block also remembers a flush it has issued. The instruction in IF/ID on the next cycle is then treated as a bubble, so a squashed instruction can never redirect fetch. The interface is plain control with no handshake: decisions are combinational from the IF/ID contents, and only the squash memory is clocked.

Top module: `brx_unit`

## Requirements
- R1: A conditional branch with opcode bits[31:26] = 000100 is taken exactly when the operand is zero.
- R2: A conditional branch with opcode bits[31:26] = 000101 is taken exactly when the operand is non-zero.
- R3: The target of a taken conditional branch is PC+4 plus the 16-bit immediate bits[15:0], sign-extended and shifted left by two. Negative offsets wrap modulo 2^32.
- R4: A jump with opcode 000010 is always taken. Its next PC is PC+4 bits[31:28], followed by instruction bits[25:0], followed by two zero bits.
- R5: A register jump (opcode 000000, function bits[5:0] = 001000) is always taken, and its next PC equals the operand.
- R6: When no redirect happens, next PC equals PC+4 and both taken and flush are 0. This covers an invalid slot, any other encoding, and a failed condition.
- R7: In mode 0, flush equals taken, and it never stays high for two consecutive cycles.
- R8: In mode 1, flush is never asserted, and the instruction after a taken branch is decoded normally. If that instruction is itself a taken branch, it redirects.
- R9: In the cycle after a flush, the IF/ID content is a bubble: taken 0, flush 0, next PC = PC+4.
- R10: Reset (active-low, asynchronous) clears the squash memory, so the first instruction after reset is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_mode | input | 1 | 0 = speculate sequential path and flush on redirect, 1 = single delay slot |
| id_valid | input | 1 | IF/ID holds a real instruction |
| id_instr | input | 32 | Instruction held in IF/ID |
| id_pc4 | input | 32 | PC+4 of that instruction |
| opnd | input | 32 | Forwarded register operand (first source field) |
| next_pc | output | 32 | Address fetch should use next |
| taken | output | 1 | Control flow leaves the sequential path |
| flush_ifid | output | 1 | Turn the fetched successor in IF/ID into a bubble |

## Verification
On every cycle, the embedded assertions check the following. The no-redirect path always falls back to PC+4. A flush always accompanies a redirect and never repeats on the next cycle. The cycle after a flush never redirects. The bench scenarios are what show correct target arithmetic: zero-test polarity, negative offsets, the jump field concatenation and the register jump value. They also show the difference between the two modes, including back-to-back taken branches where the second one is a squashed bubble in mode 0 but a live delay-slot instruction in mode 1.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam logic [OP_W-1:0] OPC_BRZ = 6'b000100;
  localparam logic [OP_W-1:0] OPC_BRNZ = 6'b000101;
  localparam logic [OP_W-1:0] OPC_JMP = 6'b000010;
  localparam logic [OP_W-1:0] OPC_REG = 6'b000000;
  localparam logic [FN_W-1:0] FN_JREG = 6'b001000;

  typedef enum logic [2:0] {
    K_NONE,
    K_BRZ,
    K_BRNZ,
    K_JMP,
    K_JREG
  } ctl_kind_t;
endpackage

// File: rtl/brx_classify.sv
module brx_classify
  import brx_pkg::*;
(
  input  logic            live,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output ctl_kind_t       kind
);
  always_comb begin
    kind = K_NONE;
    if (live) begin
      unique case (opcode)
        OPC_BRZ:  kind = K_BRZ;
        OPC_BRNZ: kind = K_BRNZ;
        OPC_JMP:  kind = K_JMP;
        OPC_REG:  kind = (funct == FN_JREG) ? K_JREG : K_NONE;
        default:  kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_kind_t       kind,
  input  logic [XLEN-1:0] opnd,
  output logic            take
);
  logic is_zero;
  assign is_zero = (opnd == '0);

  always_comb begin
    unique case (kind)
      K_BRZ:         take = is_zero;
      K_BRNZ:        take = !is_zero;
      K_JMP, K_JREG: take = 1'b1;
      default:       take = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JT_W  = 26
) (
  input  ctl_kind_t        kind,
  input  logic [XLEN-1:0]  pc4,
  input  logic [XLEN-1:0]  opnd,
  input  logic [IMM_W-1:0] imm,
  input  logic [JT_W-1:0]  jfield,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - IMM_W - 2;
  localparam int HI_W  = XLEN - JT_W - 2;

  logic [XLEN-1:0] offs, br_tgt, j_tgt;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offs = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    end else begin : g_trunc
      assign offs = {imm[XLEN-3:0], 2'b00};
    end
    if (HI_W > 0) begin : g_jhi
      assign j_tgt = {pc4[XLEN-1 -: HI_W], jfield, 2'b00};
    end else begin : g_jlo
      assign j_tgt = {jfield[XLEN-3:0], 2'b00};
    end
  endgenerate

  assign br_tgt = pc4 + offs;

  always_comb begin
    unique case (kind)
      K_JMP:   target = j_tgt;
      K_JREG:  target = opnd;
      default: target = br_tgt;
    endcase
  end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JT_W  = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_mode,
  input  logic            id_valid,
  input  logic [XLEN-1:0] id_instr,
  input  logic [XLEN-1:0] id_pc4,
  input  logic [XLEN-1:0] opnd,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            flush_ifid
);
  ctl_kind_t       kind;
  logic            squash_q, live, take;
  logic [XLEN-1:0] target;

  // the cycle after a flush, IF/ID holds a bubble
  assign live = id_valid && !squash_q;

  brx_classify u_cls (
    .live   (live),
    .opcode (id_instr[XLEN-1 -: OP_W]),
    .funct  (id_instr[FN_W-1:0]),
    .kind   (kind)
  );

  brx_cond #(.XLEN(XLEN)) u_cond (
    .kind (kind),
    .opnd (opnd),
    .take (take)
  );

  brx_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JT_W(JT_W)) u_tgt (
    .kind   (kind),
    .pc4    (id_pc4),
    .opnd   (opnd),
    .imm    (id_instr[IMM_W-1:0]),
    .jfield (id_instr[JT_W-1:0]),
    .target (target)
  );

  assign taken      = take;
  assign next_pc    = take ? target : id_pc4;
  assign flush_ifid = take && !slot_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) squash_q <= 1'b0;
    else        squash_q <= flush_ifid;
  end

  // R6
  seq_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (next_pc == id_pc4));

  // R7
  flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ifid |-> (taken && !slot_mode));

  // R7
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ifid |=> !flush_ifid);

  // R9
  bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ifid |=> (!taken && next_pc == id_pc4));
endmodule

// File: tb/test_brx_unit.sv
module test_brx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_mode = 1'b0;
  logic        id_valid = 1'b0;
  logic [31:0] id_instr = '0;
  logic [31:0] id_pc4 = '0;
  logic [31:0] opnd = '0;
  logic [31:0] next_pc;
  logic        taken, flush_ifid;

  int vectors = 0;
  int miscompares = 0;
  bit model_sq = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brx_unit i_brx_unit (
    .clk(clk), .rst_n(rst_n), .slot_mode(slot_mode), .id_valid(id_valid),
    .id_instr(id_instr), .id_pc4(id_pc4), .opnd(opnd),
    .next_pc(next_pc), .taken(taken), .flush_ifid(flush_ifid)
  );

  function automatic logic [31:0] i_brz(input logic [15:0] off);
    return {6'd4, 5'd1, 5'd0, off};
  endfunction
  function automatic logic [31:0] i_brnz(input logic [15:0] off);
    return {6'd5, 5'd1, 5'd0, off};
  endfunction
  function automatic logic [31:0] i_jmp(input logic [25:0] f);
    return {6'd2, f};
  endfunction
  function automatic logic [31:0] i_jr();
    return {6'd0, 5'd1, 15'd0, 6'd8};
  endfunction

  task automatic apply(input string req, input bit md, input bit v,
                       input logic [31:0] ins, input logic [31:0] p4,
                       input logic [31:0] a);
    bit   e_tk, e_fl;
    logic [31:0] e_pc;
    @(negedge clk);
    slot_mode = md; id_valid = v; id_instr = ins; id_pc4 = p4; opnd = a;
    #4;
    e_tk = 1'b0;
    e_pc = p4;
    if (v && !model_sq) begin
      case (ins[31:26])
        6'd4: if (a == 0) begin e_tk = 1; e_pc = p4 + 32'(signed'(ins[15:0])) * 4; end
        6'd5: if (a != 0) begin e_tk = 1; e_pc = p4 + 32'(signed'(ins[15:0])) * 4; end
        6'd2: begin e_tk = 1; e_pc = (p4 & 32'hF000_0000) | (32'(ins[25:0]) << 2); end
        6'd0: if (ins[5:0] == 6'd8) begin e_tk = 1; e_pc = a; end
        default: ;
      endcase
    end
    e_fl = e_tk && !md;
    vectors++;
    if (taken !== e_tk || flush_ifid !== e_fl || next_pc !== e_pc) begin
      miscompares++;
      $display("FAIL %s: taken=%0b flush=%0b next_pc=%h expected taken=%0b flush=%0b next_pc=%h",
               req, taken, flush_ifid, next_pc, e_tk, e_fl, e_pc);
    end
    @(posedge clk);
    #1 model_sq = rst_n ? e_fl : 1'b0;
  endtask

  initial begin
    // R10: outputs idle during reset, squash memory clear afterwards
    apply("R10", 0, 0, i_brz(16'd3), 32'h0000_1000, 32'd0);
    apply("R10", 0, 0, i_jmp(26'h40), 32'h0000_1000, 32'd0);
    rst_n = 1'b1;
    apply("R10", 0, 1, i_brz(16'd3), 32'h0000_1000, 32'd0);
    // R9: successor of that flushed redirect is a bubble
    apply("R9", 0, 1, i_brz(16'd3), 32'h0000_1004, 32'd0);
    // R1 not taken, R6
    apply("R1", 0, 1, i_brz(16'd3), 32'h0000_1008, 32'd5);
    // R2 taken with negative offset, R3
    apply("R2", 0, 1, i_brnz(16'hFFFE), 32'h0000_2000, 32'd5);
    apply("R9", 0, 1, i_jmp(26'h40), 32'h0000_2004, 32'd0);
    apply("R2", 0, 1, i_brnz(16'd7), 32'h0000_2008, 32'd0);
    // R3 wrap-around
    apply("R3", 0, 1, i_brz(16'h8000), 32'h0000_0010, 32'd0);
    apply("R6", 0, 0, 32'h0, 32'h0000_0014, 32'd0);
    // R4 jump keeps PC+4 upper bits
    apply("R4", 0, 1, i_jmp(26'h3FF_FFFF), 32'hA000_0010, 32'd0);
    apply("R9", 0, 1, i_jr(), 32'hA000_0014, 32'h1234_5678);
    // R5 register jump
    apply("R5", 0, 1, i_jr(), 32'h0000_3000, 32'h1234_5678);
    apply("R6", 0, 0, 32'h0, 32'h0000_3004, 32'd0);
    // R6 other encodings
    apply("R6", 0, 1, {6'd0, 20'd0, 6'd9}, 32'h0000_3008, 32'd0);
    apply("R6", 0, 1, {6'd8, 26'h40}, 32'h0000_300C, 32'd0);
    // R8 delay-slot mode: back-to-back redirects both live, no flush
    apply("R8", 1, 1, i_brz(16'd4), 32'h0000_4000, 32'd0);
    apply("R8", 1, 1, i_brnz(16'd2), 32'h0000_4004, 32'd9);
    apply("R8", 1, 1, i_jmp(26'h123), 32'h5000_0000, 32'd0);
    apply("R8", 1, 1, i_jr(), 32'h5000_0004, 32'hDEAD_BEE0);
    apply("R8", 1, 1, i_brz(16'd4), 32'h0000_4100, 32'd1);
    apply("R8", 1, 1, i_brnz(16'd4), 32'h0000_4104, 32'd0);
    // R7 back to mode 0: consecutive flush suppressed
    apply("R7", 0, 1, i_jr(), 32'h0000_6000, 32'h0000_0100);
    apply("R7", 0, 1, i_jr(), 32'h0000_6004, 32'h0000_0200);
    apply("R7", 0, 1, i_jr(), 32'h0000_6008, 32'h0000_0300);
    apply("R1", 0, 1, i_brz(16'hFFFF), 32'h0000_7000, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule